// File: doc/BRIEF.md
# Pin Controller with Polarity-Adjusted Edge and Level Interrupts

This block is a register-mapped general-purpose pin controller for up to 32 pins. Software reaches it through a plain single-cycle write strobe and a combinational read port. Each pin has four configuration bits: an output value, an active-low direction bit, a blink enable and an input inversion bit. It also has an edge-interrupt enable, a level-interrupt enable and a sticky cause flag that records a rising edge.

The incoming pin levels first pass through a two-stage synchroniser. They are then XORed with the inversion register. That adjusted value is what software reads as input data. It is also what feeds both the level interrupt term and the rising-edge detector that sets the cause flags. Because of this, flipping a pin's inversion bit lets software catch the opposite edge. A single interrupt line combines every enabled edge and level term over all pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction register reads all ones for the implemented pins. Every other register reads zero, `pad_oe` is all zeros, `pad_out` is all zeros and `irq` is 0.
- R2: The register is selected by `bus_addr[4:2]`: 0 output value, 1 direction (active low), 2 blink enable, 3 input inversion, 4 input data (read-only), 5 cause, 6 edge-interrupt enable (byte offset 0x18), 7 level-interrupt enable (byte offset 0x1C). Bits at and above NUM_PINS read 0.
- R3: For each pin, `pad_oe` is 1 exactly when its direction bit is 0. `pad_out` shows the output value register whether or not the pin is driven, so a value can be preset before the pin is enabled.
- R4: Input data bit i reads as the synchronised pin level XOR inversion bit i. It reflects a pin change two clock edges after the change. Writes to the input data address change nothing.
- R5: A cause bit is set on the third clock edge after a 0-to-1 change of its adjusted input. A 1-to-0 change of the adjusted input does not set it. With the inversion bit set, a falling pin sets it. A cause bit stays set until software clears it.
- R6: A write to the cause address clears every bit written as 0 and leaves every bit written as 1 unchanged. A new edge that arrives on the same clock edge as a clearing write leaves the bit set.
- R7: `irq` is the OR over all pins of (cause AND edge enable) OR (input data AND level enable). It follows register state with no extra cycle of delay.
- R8: For a pin with blink enabled, `pad_out` is the output value XOR a shared phase. The phase starts at 0 and inverts every BLINK_HALF clock cycles. Pins without blink hold a static level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pin levels, asynchronous |
| pad_out | output | NUM_PINS | Value to drive on each pin |
| pad_oe | output | NUM_PINS | Drive enable per pin, active high |
| irq | output | 1 | Combined interrupt request |

## Verification
The input path is swept over every one of the 256 pin patterns on an eight-pin build, under four inversion patterns. All ones and all zeros separate an inverted path from a plain one. Alternating patterns expose swapped or shifted bit lanes. Edge detection is walked one pin at a time in both directions, with and without inversion. This separates rise-only capture from any-change capture and shows that each pin lands in its own cause bit. A rising edge is timed to meet a clearing write on the same clock edge to check that the new event wins. Interrupt combining is tried with enables on the wrong pin and the right pin, for edge and level terms separately.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 5;
    localparam int REG_SEL_W = 3;

    // Word index taken from bus_addr[4:2]; slots 6 and 7 land at 0x18 / 0x1C.
    typedef enum logic [REG_SEL_W-1:0] {
        SEL_DOUT  = 3'd0,
        SEL_DIR_N = 3'd1,
        SEL_BLINK = 3'd2,
        SEL_INV   = 3'd3,
        SEL_DIN   = 3'd4,
        SEL_CAUSE = 3'd5,
        SEL_EMASK = 3'd6,
        SEL_LMASK = 3'd7
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr[ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] inv,
    output logic [NUM_PINS-1:0] din,
    output logic [NUM_PINS-1:0] rise
);

    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] sync;
        logic [NUM_PINS-1:0] prev;
    } in_state_t;

    in_state_t st_d, st_q;
    logic [NUM_PINS-1:0] adj;

    always_comb begin
        adj       = st_q.sync ^ inv;
        st_d      = st_q;
        st_d.meta = pin_raw;
        st_d.sync = st_q.meta;
        st_d.prev = adj;
        din       = adj;
        rise      = adj & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int BLINK_HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);

    localparam int CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } blink_state_t;

    blink_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        phase = st_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int BLINK_HALF = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic              irq
);

    typedef logic [NUM_PINS-1:0] vec_t;

    typedef struct packed {
        vec_t dout;
        vec_t dir_n;
        vec_t blink;
        vec_t inv;
        vec_t cause;
        vec_t emask;
        vec_t lmask;
    } regs_t;

    regs_t    st_d, st_q;
    vec_t     din, rise, wvec;
    logic     phase;
    reg_sel_e sel;

    gpio_in_stage #(.NUM_PINS(NUM_PINS)) in_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_in),
        .inv     (st_q.inv),
        .din     (din),
        .rise    (rise)
    );

    gpio_blink_gen #(.BLINK_HALF(BLINK_HALF)) blink_i (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    generate
        if (NUM_PINS < BUS_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^bus_wdata[BUS_W-1:NUM_PINS];
        end
    endgenerate
    logic unused_lo;
    assign unused_lo = ^bus_addr[1:0];

    // Next-state: register writes and cause capture.
    always_comb begin
        sel  = decode_sel(bus_addr);
        wvec = bus_wdata[NUM_PINS-1:0];
        st_d = st_q;
        if (bus_wen) begin
            unique case (sel)
                SEL_DOUT:  st_d.dout  = wvec;
                SEL_DIR_N: st_d.dir_n = wvec;
                SEL_BLINK: st_d.blink = wvec;
                SEL_INV:   st_d.inv   = wvec;
                SEL_CAUSE: st_d.cause = st_q.cause & wvec;
                SEL_EMASK: st_d.emask = wvec;
                SEL_LMASK: st_d.lmask = wvec;
                default:   ;
            endcase
        end
        // A fresh edge wins over a clearing write on the same edge.
        st_d.cause = st_d.cause | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dir_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux and pin-facing outputs.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DOUT:  bus_rdata[NUM_PINS-1:0] = st_q.dout;
            SEL_DIR_N: bus_rdata[NUM_PINS-1:0] = st_q.dir_n;
            SEL_BLINK: bus_rdata[NUM_PINS-1:0] = st_q.blink;
            SEL_INV:   bus_rdata[NUM_PINS-1:0] = st_q.inv;
            SEL_DIN:   bus_rdata[NUM_PINS-1:0] = din;
            SEL_CAUSE: bus_rdata[NUM_PINS-1:0] = st_q.cause;
            SEL_EMASK: bus_rdata[NUM_PINS-1:0] = st_q.emask;
            SEL_LMASK: bus_rdata[NUM_PINS-1:0] = st_q.lmask;
            default:   ;
        endcase
        pad_out = st_q.dout ^ (st_q.blink & {NUM_PINS{phase}});
        pad_oe  = ~st_q.dir_n;
        irq     = |((st_q.cause & st_q.emask) | (din & st_q.lmask));
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wen,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] cause_q,
    input logic [NUM_PINS-1:0] rise,
    input logic [NUM_PINS-1:0] emask_q,
    input logic [NUM_PINS-1:0] lmask_q
);

    logic wr_dir, wr_cause;
    assign wr_dir   = bus_wen && (bus_addr[4:2] == SEL_DIR_N);
    assign wr_cause = bus_wen && (bus_addr[4:2] == SEL_CAUSE);

    // R3
    a_r3_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pad_oe == ~$past(bus_wdata[NUM_PINS-1:0])));

    // R6
    a_r6_cause_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> (cause_q == (($past(cause_q) & $past(bus_wdata[NUM_PINS-1:0]))
                                  | $past(rise))));

    // R5
    a_r5_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cause |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R5
    a_r5_rise_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((cause_q & $past(rise)) == $past(rise)));

    // R7
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> !irq);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .cause_q   (st_q.cause),
    .rise      (rise),
    .emask_q   (st_q.emask),
    .lmask_q   (st_q.lmask)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;

    localparam int NP = 8;
    localparam int BH = 4;

    localparam logic [4:0] A_DOUT  = 5'h00;
    localparam logic [4:0] A_DIR   = 5'h04;
    localparam logic [4:0] A_BLINK = 5'h08;
    localparam logic [4:0] A_INV   = 5'h0C;
    localparam logic [4:0] A_DIN   = 5'h10;
    localparam logic [4:0] A_CAUSE = 5'h14;
    localparam logic [4:0] A_EMASK = 5'h18;
    localparam logic [4:0] A_LMASK = 5'h1C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_wen = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP), .BLINK_HALF(BH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pols [4];
        int toggles;
        logic last;
        pols[0] = 8'h00; pols[1] = 8'hFF; pols[2] = 8'hA5; pols[3] = 8'h5A;

        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg("R1 dout", A_DOUT, 32'h0);
        chk_reg("R1 dir", A_DIR, 32'hFF);
        chk_reg("R1 blink", A_BLINK, 32'h0);
        chk_reg("R1 inv", A_INV, 32'h0);
        chk_reg("R1 cause", A_CAUSE, 32'h0);
        chk_reg("R1 emask", A_EMASK, 32'h0);
        chk_reg("R1 lmask", A_LMASK, 32'h0);
        chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
        chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R4 input sweep
        for (int k = 0; k < 4; k++) begin
            wr(A_INV, {24'h0, pols[k]});
            for (int p = 0; p < 256; p++) begin
                pin_in = p[7:0];
                tick(2);
                chk_reg("R4 din sweep", A_DIN, {24'h0, p[7:0] ^ pols[k]});
            end
        end

        // R5 rising edges per pin
        wr(A_INV, 32'h0);
        pin_in = '0;
        tick(4);
        wr(A_CAUSE, 32'h0);
        for (int i = 0; i < NP; i++) begin
            pin_in = 8'(1 << i);
            tick(3);
            chk_reg("R5 rise sets cause", A_CAUSE, 32'(1 << i));
            pin_in = '0;
            tick(3);
            chk_reg("R5 fall no set", A_CAUSE, 32'(1 << i));
            wr(A_CAUSE, 32'h0);
            chk_reg("R6 clear cause", A_CAUSE, 32'h0);
        end

        // R5 inversion catches falling edges
        pin_in = 8'hFF;
        tick(4);
        wr(A_INV, 32'hFF);
        tick(2);
        wr(A_CAUSE, 32'h0);
        chk_reg("R5 inv change no rise", A_CAUSE, 32'h0);
        pin_in = 8'h00;
        tick(3);
        chk_reg("R5 inverted fall sets", A_CAUSE, 32'hFF);

        // R6 write one keeps, write zero clears
        wr(A_CAUSE, 32'h0F);
        chk_reg("R6 partial clear", A_CAUSE, 32'h0F);
        wr(A_CAUSE, 32'hFF);
        chk_reg("R6 write one keeps", A_CAUSE, 32'h0F);

        // R6 set wins over same-edge clear
        wr(A_INV, 32'h0);
        tick(2);
        wr(A_CAUSE, 32'h0);
        pin_in = 8'h01;
        tick(2);
        wr(A_CAUSE, 32'h0);
        chk_reg("R6 set wins", A_CAUSE, 32'h01);

        // R7 interrupt combining
        chk("R7 no enables", {31'h0, irq}, 32'h0);
        wr(A_EMASK, 32'h02);
        chk("R7 edge wrong pin", {31'h0, irq}, 32'h0);
        wr(A_EMASK, 32'h01);
        chk("R7 edge right pin", {31'h0, irq}, 32'h1);
        wr(A_CAUSE, 32'h0);
        chk("R7 edge cleared", {31'h0, irq}, 32'h0);
        pin_in = 8'h80;
        tick(2);
        wr(A_LMASK, 32'h40);
        chk("R7 level wrong pin", {31'h0, irq}, 32'h0);
        wr(A_LMASK, 32'h80);
        chk("R7 level right pin", {31'h0, irq}, 32'h1);
        wr(A_INV, 32'h80);
        chk("R7 level inverted off", {31'h0, irq}, 32'h0);
        wr(A_EMASK, 32'h0);
        wr(A_LMASK, 32'h0);

        // R4 write to input data ignored
        pin_in = 8'h55;
        tick(2);
        wr(A_DIN, 32'hFFFF_FFFF);
        chk_reg("R4 din write ignored", A_DIN, 32'hD5);
        chk_reg("R4 inv untouched", A_INV, 32'h80);

        // R3 pad drive
        wr(A_DOUT, 32'h3C);
        wr(A_DIR, 32'hF0);
        chk("R3 pad_oe", {24'h0, pad_oe}, 32'h0F);
        chk("R3 pad_out", {24'h0, pad_out}, 32'h3C);

        // R2 register map readback with upper bits
        wr(A_DOUT, 32'hFFFF_FFFF);  chk_reg("R2 dout", A_DOUT, 32'hFF);
        wr(A_DIR, 32'hFFFF_FFA5);   chk_reg("R2 dir", A_DIR, 32'hA5);
        wr(A_BLINK, 32'h1234_5600); chk_reg("R2 blink", A_BLINK, 32'h00);
        wr(A_INV, 32'hFFFF_FF5A);   chk_reg("R2 inv", A_INV, 32'h5A);
        wr(A_EMASK, 32'hABCD_EF3C); chk_reg("R2 emask", A_EMASK, 32'h3C);
        wr(A_LMASK, 32'h0000_01C3); chk_reg("R2 lmask", A_LMASK, 32'hC3);
        wr(A_EMASK, 32'h0);
        wr(A_LMASK, 32'h0);

        // R8 blink
        wr(A_DOUT, 32'h03);
        wr(A_BLINK, 32'h01);
        toggles = 0;
        last = pad_out[0];
        for (int c = 0; c < 4 * BH; c++) begin
            tick(1);
            if (pad_out[0] != last) toggles++;
            last = pad_out[0];
            chk("R8 static pin", {31'h0, pad_out[1]}, 32'h1);
        end
        chk("R8 blink toggles", 32'(toggles), 32'(4));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule